// File: doc/BRIEF.md
# Reset and Stop-Mode Wake Sequencer

This block produces the internal reset and the core clock enable for a small controller that runs from a crystal oscillator. After the supply comes up it keeps the core in reset until a fixed number of oscillator clocks have gone by, so the crystal has time to settle. It also raises a sticky flag that tells software a power-on reset took place. The external reset pin is active high and is synchronized to the oscillator clock. The block counts the oscillator clock, which keeps running while the core clock is gated.

Software puts the core into stop mode by writing a one to the stop bit. The core clock is then gated off. Only two things end stop mode:
- an edge of the chosen direction on one of the added external wake lines;
- the external reset pin.

Interrupts raised inside the chip cannot wake it, because they need a running clock. Before the core clock comes back, the same settling count passes again. The stop bit clears itself when the wake-up starts, so the core does not go straight back into stop. All outputs are plain control and status levels. The block has no data stream, so none of its pins use a valid/ready handshake.

Top module: `rsq_reset_sequencer`

## Requirements
- R1: While `por_n_i` is low, `core_rst_o`=1, `core_clk_en_o`=0, `por_flag_o`=1 and `stop_bit_o`=0. After `por_n_i` rises, with the pin reset low, `core_rst_o` falls and `core_clk_en_o` rises after exactly SETTLE_CLKS rising clock edges.
- R2: `por_flag_o` is set only by the power-up reset. It stays set through pin resets and clears one edge after `por_flag_clr_i` is sampled high.
- R3: A write (`pwrctl_we_i`=1) with `pwrctl_stop_i`=1 while the core runs enters stop on that edge. After that edge `stop_bit_o`=1, `core_clk_en_o`=0 and `core_rst_o`=0.
- R4: Wake line k, where k is the bit index in `wake_line_i`, wakes the block on a rising edge when bit k of WAKE_RISING is 1 and on a falling edge when it is 0. The default is 4'b0101, so lines 0 and 2 wake on rising edges and lines 1 and 3 on falling edges. The wake-up starts on the 3rd rising clock edge after the line changes. `core_clk_en_o` returns SETTLE_CLKS edges later, so 3+SETTLE_CLKS edges after the change in total. `core_rst_o` stays 0 throughout.
- R5: An edge in the opposite direction on a wake line, or any wake-line edge while the core runs, leaves the state unchanged. A stopped block stays stopped and a running block keeps `core_clk_en_o`=1.
- R6: `stop_bit_o` reads 0 from the edge on which the wake-up starts, while `core_clk_en_o` is still 0.
- R7: A high level on `ext_rst_i` while the core runs sets `core_rst_o`=1 from the 3rd edge after it rises, and `core_clk_en_o` stays 1. `core_rst_o` falls on the 3rd edge after `ext_rst_i` drops.
- R8: A high level on `ext_rst_i` during stop or during the wake-up count sets `core_rst_o`=1 and clears `stop_bit_o`. The core stays in reset for as long as the pin is high. `core_rst_o` falls and `core_clk_en_o` rises 2+SETTLE_CLKS edges after the pin drops.
- R9: A write with `pwrctl_stop_i`=0 while the core runs does not enter stop. `stop_bit_o` stays 0 and `core_clk_en_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| por_n_i | input | 1 | Power-up indication, low while the supply is not yet good (asynchronous) |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous |
| pwrctl_we_i | input | 1 | Write strobe for the power control stop bit |
| pwrctl_stop_i | input | 1 | Value written to the stop bit |
| por_flag_clr_i | input | 1 | Software clear of the power-on flag |
| wake_line_i | input | NUM_WAKE | Asynchronous external wake lines |
| core_rst_o | output | 1 | Reset to the core, active high |
| core_clk_en_o | output | 1 | Core clock enable |
| por_flag_o | output | 1 | Power-on reset happened |
| stop_bit_o | output | 1 | Current stop bit |

## Verification
The wake path is driven from a table. Each wake line gets an edge in its own direction, which separates a correct per-line polarity from a swapped or shared one. Two further entries first give the opposite edge and then the correct one, which shows that only the chosen direction wakes the block. Each wake-up is timed edge by edge to show that a full settling window passes and that the stop bit clears at its start. Pin resets are applied in three states, running, stopped and mid-count, and the release timing differs in each: a running core leaves reset after the synchronizer delay, while a stopped or counting one must wait out the whole settling count.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    SQ_HOLD   = 3'd0,  // settling count with core in reset
    SQ_PINRST = 3'd1,  // pin reset while oscillator stable
    SQ_RUN    = 3'd2,  // core running
    SQ_STOP   = 3'd3,  // core clock gated, waiting for wake
    SQ_WAKE   = 3'd4   // settling count before clock resumes
  } sq_state_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int          WIDTH     = 1,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rsq_wake_edge.sv
module rsq_wake_edge #(
  parameter int                  NUM_WAKE    = 4,
  parameter logic [NUM_WAKE-1:0] WAKE_RISING = 4'b0101
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic [NUM_WAKE-1:0] line_sync_i,
  output logic                wake_hit_o
);
  localparam logic [NUM_WAKE-1:0] IDLE_LVL = ~WAKE_RISING;

  logic [NUM_WAKE-1:0] prev_q;
  logic [NUM_WAKE-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) prev_q <= IDLE_LVL;
    else          prev_q <= line_sync_i;
  end

  for (genvar k = 0; k < NUM_WAKE; k++) begin : g_line
    if (WAKE_RISING[k]) begin : g_rise
      assign hit[k] = line_sync_i[k] & ~prev_q[k];
    end else begin : g_fall
      assign hit[k] = ~line_sync_i[k] & prev_q[k];
    end
  end

  assign wake_hit_o = |hit;
endmodule

// File: rtl/rsq_settle_timer.sv
module rsq_settle_timer #(
  parameter int SETTLE_CLKS = 65536
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int         CNT_W = (SETTLE_CLKS > 2) ? $clog2(SETTLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/rsq_reset_sequencer.sv
module rsq_reset_sequencer
  import rsq_pkg::*;
#(
  parameter int                  SETTLE_CLKS = 65536,
  parameter int                  NUM_WAKE    = 4,
  parameter logic [NUM_WAKE-1:0] WAKE_RISING = 4'b0101,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                por_n_i,
  input  logic                ext_rst_i,
  input  logic                pwrctl_we_i,
  input  logic                pwrctl_stop_i,
  input  logic                por_flag_clr_i,
  input  logic [NUM_WAKE-1:0] wake_line_i,
  output logic                core_rst_o,
  output logic                core_clk_en_o,
  output logic                por_flag_o,
  output logic                stop_bit_o
);
  localparam logic [NUM_WAKE-1:0] IDLE_LVL = ~WAKE_RISING;

  sq_state_e           state_q, state_d;
  logic                ext_sync;
  logic [NUM_WAKE-1:0] wake_sync;
  logic                wake_hit;
  logic                settle_done;
  logic                timer_clr;
  logic                stop_q, stop_d;
  logic                por_flag_q;

  rsq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ext_sync (
    .clk_i(clk_i), .rst_n_i(por_n_i), .d_i(ext_rst_i), .q_o(ext_sync)
  );

  rsq_sync #(.WIDTH(NUM_WAKE), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LVL)) u_wake_sync (
    .clk_i(clk_i), .rst_n_i(por_n_i), .d_i(wake_line_i), .q_o(wake_sync)
  );

  rsq_wake_edge #(.NUM_WAKE(NUM_WAKE), .WAKE_RISING(WAKE_RISING)) u_wake_edge (
    .clk_i(clk_i), .rst_n_i(por_n_i), .line_sync_i(wake_sync), .wake_hit_o(wake_hit)
  );

  // Counter runs only in the two settling states and restarts while the pin holds reset.
  assign timer_clr = ext_sync || !(state_q == SQ_HOLD || state_q == SQ_WAKE);

  rsq_settle_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_timer (
    .clk_i(clk_i), .rst_n_i(por_n_i), .clr_i(timer_clr), .done_o(settle_done)
  );

  always_comb begin
    state_d = state_q;
    stop_d  = stop_q;
    unique case (state_q)
      SQ_HOLD: begin
        stop_d = 1'b0;
        if (!ext_sync && settle_done) state_d = SQ_RUN;
      end
      SQ_PINRST: begin
        stop_d = 1'b0;
        if (!ext_sync) state_d = SQ_RUN;
      end
      SQ_RUN: begin
        if (ext_sync) begin
          state_d = SQ_PINRST;
          stop_d  = 1'b0;
        end else if (pwrctl_we_i) begin
          stop_d = pwrctl_stop_i;
          if (pwrctl_stop_i) state_d = SQ_STOP;
        end
      end
      SQ_STOP: begin
        if (ext_sync) begin
          state_d = SQ_HOLD;
          stop_d  = 1'b0;
        end else if (wake_hit) begin
          state_d = SQ_WAKE;
          stop_d  = 1'b0;
        end
      end
      SQ_WAKE: begin
        stop_d = 1'b0;
        if (ext_sync)         state_d = SQ_HOLD;
        else if (settle_done) state_d = SQ_RUN;
      end
      default: begin
        state_d = SQ_HOLD;
        stop_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      state_q <= SQ_HOLD;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
    end
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)            por_flag_q <= 1'b1;
    else if (por_flag_clr_i) por_flag_q <= 1'b0;
  end

  assign core_rst_o    = (state_q == SQ_HOLD) || (state_q == SQ_PINRST);
  assign core_clk_en_o = (state_q == SQ_RUN)  || (state_q == SQ_PINRST);
  assign por_flag_o    = por_flag_q;
  assign stop_bit_o    = stop_q;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int SETTLE_CLKS = 65536
) (
  input logic clk_i,
  input logic por_n_i,
  input logic por_flag_clr_i,
  input logic core_rst_o,
  input logic core_clk_en_o,
  input logic por_flag_o,
  input logic stop_bit_o
);
  int gated_cnt;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)                      gated_cnt <= 0;
    else if (core_clk_en_o)            gated_cnt <= 0;
    else if (gated_cnt < SETTLE_CLKS + 8) gated_cnt <= gated_cnt + 1;
  end

  assert_flag_sticky_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (por_flag_o && !por_flag_clr_i) |=> por_flag_o);

  assert_flag_no_set_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !por_flag_o |=> !por_flag_o);

  assert_stop_gates_clock_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
    stop_bit_o |-> (!core_clk_en_o && !core_rst_o));

  assert_release_with_clock_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(core_rst_o) |-> core_clk_en_o);

  assert_settle_window_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    ($rose(core_clk_en_o) && !$past(core_rst_o)) |-> (gated_cnt >= SETTLE_CLKS));
endmodule

bind rsq_reset_sequencer rsq_checker #(.SETTLE_CLKS(SETTLE_CLKS)) u_rsq_checker (
  .clk_i(clk_i),
  .por_n_i(por_n_i),
  .por_flag_clr_i(por_flag_clr_i),
  .core_rst_o(core_rst_o),
  .core_clk_en_o(core_clk_en_o),
  .por_flag_o(por_flag_o),
  .stop_bit_o(stop_bit_o)
);

// File: tb/test_rsq_reset_sequencer.sv
`timescale 1ns/1ps
module test_rsq_reset_sequencer;
  localparam int         SETTLE = 32;
  localparam int         NW     = 4;
  localparam logic [3:0] RISE   = 4'b0101;
  localparam logic [3:0] IDLE   = ~RISE;
  localparam int         NVEC   = 6;
  // vector: [1:0] line, [2] opposite edge first (must not wake)
  localparam logic [2:0] VEC [NVEC] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b111};

  logic clk = 1'b0;
  logic por_n, ext_rst, pwr_we, pwr_stop, flag_clr;
  logic [NW-1:0] wake;
  logic core_rst, clk_en, por_flag, stop_bit;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  rsq_reset_sequencer #(.SETTLE_CLKS(SETTLE), .NUM_WAKE(NW), .WAKE_RISING(RISE)) i_rsq_reset_sequencer (
    .clk_i(clk), .por_n_i(por_n), .ext_rst_i(ext_rst), .pwrctl_we_i(pwr_we),
    .pwrctl_stop_i(pwr_stop), .por_flag_clr_i(flag_clr), .wake_line_i(wake),
    .core_rst_o(core_rst), .core_clk_en_o(clk_en), .por_flag_o(por_flag), .stop_bit_o(stop_bit)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_until_run(output int n);
    n = 0;
    while (!(clk_en && !core_rst) && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic enter_stop();
    pwr_we = 1'b1; pwr_stop = 1'b1;
    step(1);
    pwr_we = 1'b0; pwr_stop = 1'b0;
    check("R3 clk_en after stop write", clk_en, 0);
    check("R3 stop_bit after stop write", stop_bit, 1);
    check("R3 core_rst in stop", core_rst, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    bit saw_rst;
    por_n = 1'b0; ext_rst = 1'b0; pwr_we = 1'b0; pwr_stop = 1'b0; flag_clr = 1'b0; wake = IDLE;
    step(3);
    check("R1 core_rst in power-up", core_rst, 1);
    check("R1 clk_en in power-up", clk_en, 0);
    check("R1 por_flag in power-up", por_flag, 1);
    check("R1 stop_bit in power-up", stop_bit, 0);

    por_n = 1'b1;
    edges_until_run(n);
    check("R1 power-up hold length", n, SETTLE);

    // pin reset while running
    ext_rst = 1'b1;
    step(2);
    check("R7 core_rst before sync", core_rst, 0);
    step(1);
    check("R7 core_rst asserted", core_rst, 1);
    check("R7 clk_en during pin reset", clk_en, 1);
    ext_rst = 1'b0;
    step(2);
    check("R7 core_rst still held", core_rst, 1);
    step(1);
    check("R7 core_rst released", core_rst, 0);
    check("R2 flag kept through pin reset", por_flag, 1);

    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check("R2 flag cleared", por_flag, 0);
    ext_rst = 1'b1; step(5); ext_rst = 1'b0; step(5);
    check("R2 flag stays clear after pin reset", por_flag, 0);

    pwr_we = 1'b1; pwr_stop = 1'b0;
    step(1);
    pwr_we = 1'b0;
    check("R9 stop_bit after zero write", stop_bit, 0);
    check("R9 clk_en after zero write", clk_en, 1);

    // table of wake vectors
    for (int v = 0; v < NVEC; v++) begin
      int ln;
      ln = int'(VEC[v][1:0]);
      if (VEC[v][2]) begin
        wake[ln] = RISE[ln];        // active level reached while running
        step(6);
        check("R5 edge while running ignored", clk_en, 1);
      end
      enter_stop();
      if (VEC[v][2]) begin
        wake[ln] = IDLE[ln];        // opposite-direction edge
        step(SETTLE + 8);
        check("R5 opposite edge no wake clk_en", clk_en, 0);
        check("R5 opposite edge no wake stop_bit", stop_bit, 1);
      end
      wake[ln] = RISE[ln];          // edge in wake direction
      step(2);
      check("R6 stop_bit before wake start", stop_bit, 1);
      step(1);
      check("R6 stop_bit cleared at wake start", stop_bit, 0);
      check("R4 clock still gated at wake start", clk_en, 0);
      n = 0; saw_rst = 0;
      while (!clk_en && n < 1000) begin
        @(negedge clk);
        n++;
        if (core_rst) saw_rst = 1;
      end
      check($sformatf("R4 line %0d settle length", ln), n, SETTLE);
      check("R4 no core reset during wake", int'(saw_rst), 0);
      wake[ln] = IDLE[ln];          // edge while running
      step(6);
      check("R5 return edge while running", clk_en, 1);
    end

    // pin reset during stop
    enter_stop();
    ext_rst = 1'b1;
    step(3);
    check("R8 core_rst from stop", core_rst, 1);
    check("R8 stop_bit cleared", stop_bit, 0);
    check("R8 clk_en gated", clk_en, 0);
    step(2 * SETTLE);
    check("R8 held while pin high", core_rst, 1);
    ext_rst = 1'b0;
    edges_until_run(n);
    check("R8 release after stop reset", n, 2 + SETTLE);

    // pin reset during the wake count
    enter_stop();
    wake[0] = RISE[0];
    step(8);
    check("R8 in wake count", clk_en, 0);
    ext_rst = 1'b1;
    step(3);
    check("R8 core_rst from wake", core_rst, 1);
    ext_rst = 1'b0;
    edges_until_run(n);
    check("R8 release after wake reset", n, 2 + SETTLE);
    wake[0] = IDLE[0];
    step(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule